// File: doc/BRIEF.md
# SPI Boot-Host Synchronization Sequencer

This block is the host side of the opening handshake with a processor that boots as an SPI slave. It drives clock, chip select and data out, and reads data back at the same time, always in 16-bit words. A word engine shifts each word and then holds chip select released for a programmable idle gap before the next word can begin. On top of it, a sequencer sends the start word until the slave returns the matching reply. It then waits for permission to move on, sends the two ping words, and reports success or one of two failure kinds.

The clock divider and the idle gap come from two register sets. The slow set is meant for the period before the slave has brought up its PLL, and the fast set for the period after it. An input picks the set, and the choice is captured when each word begins. Because the slave imposes no time limit between the two phases, the sequencer parks after start-word success until `ping_go` is raised. The host can use that pause to reconfigure the slave's clocking and switch to the fast set. Sending the boot image is left to other logic.

Top module: `spi_boot_sync`

## Requirements
- R1: After reset, `cs_n` = 1, `sclk` = 1, `mosi` = 0, and `synced`, `done`, `err_start` and `err_ping` are all 0.
- R2: Every word is framed by `cs_n` low with exactly 16 rising `sclk` edges, most significant bit first. `sclk` rests high whenever `cs_n` is high, so the first edge of a word is falling. `mosi` changes only together with a falling `sclk` edge, and `miso` is sampled at the rising edges.
- R3: A pulse on `start` makes the block send 0x5853. When the word read back during that transfer is 0x5253, `synced` goes to 1.
- R4: When the read-back differs from 0x5253, the start word is sent again. At most `retry_limit`+1 start words are sent in total, and a match on any of them sets `synced`.
- R5: If `retry_limit`+1 start words all fail, `err_start` goes to 1 and no further word is sent.
- R6: After `synced` rises, no word is sent while `ping_go` is 0, however long it stays 0. Once `ping_go` is 1, the block sends 0x590B and then 0x5853 as two separate words.
- R7: `done` goes to 1 when the word read back during the second ping word equals `ping_expect` and is not 0x0000.
- R8: `err_ping` goes to 1 when that word differs from `ping_expect`, or when it is 0x0000, even if `ping_expect` is 0x0000.
- R9: Between any two words, `cs_n` stays high for at least gap+1 clock cycles, where gap is the gap value of the set in force.
- R10: Each `sclk` level within a word lasts div+1 clock cycles. `use_fast` = 0 selects `slow_div`/`slow_gap`, and `use_fast` = 1 selects `fast_div`/`fast_gap`.
- R11: The set is captured when `cs_n` falls. A change of `use_fast` during a word does not alter that word's timing, and the next word uses the new set.
- R12: At most one of `done`, `err_start` and `err_ping` is 1 at a time. A set flag holds until the next `start`, which clears all flags and `synced` and begins the handshake again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse: begin handshake (accepted when idle or finished) |
| ping_go | input | 1 | Level: allow the ping phase after start-word success |
| use_fast | input | 1 | 0 = slow set, 1 = fast set |
| slow_div | input | DIV_W | Slow set: sclk half period minus one, in clock cycles |
| slow_gap | input | GAP_W | Slow set: minimum idle gap minus one, in clock cycles |
| fast_div | input | DIV_W | Fast set: sclk half period minus one |
| fast_gap | input | GAP_W | Fast set: minimum idle gap minus one |
| retry_limit | input | RETRY_W | Number of start-word resends allowed |
| ping_expect | input | 16 | Expected read-back during the second ping word |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Chip select, active low, one assertion per word |
| mosi | output | 1 | Serial data to slave |
| synced | output | 1 | Start-word phase succeeded |
| done | output | 1 | Ping phase succeeded |
| err_start | output | 1 | Start-word retries exhausted |
| err_ping | output | 1 | Ping read-back wrong or zero |

## Verification
A bench slave model records every word it receives and returns queued replies, and a clock-cycle monitor measures `sclk` level lengths and `cs_n` idle runs for each word. A correct first reply separates the plain path from the retry path. A mismatch followed by a match shows that resending stops as soon as the match arrives. Replies that always mismatch show that the resend count stops at the limit. For the ping check, a matching reply, a wrong reply, and a zero reply against a zero expectation distinguish value comparison from the zero-rejection rule. Runs on the slow set, on the fast set, and with `use_fast` flipped in the middle of a word show that timing follows the set captured at chip-select fall. A long hold with `ping_go` low shows that the block waits between the phases with no limit.

// File: rtl/spi_boot_pkg.sv
// Package: shared constants and state types for the SPI boot-host sequencer.
// Assumes a fixed 16-bit word on the link.
package spi_boot_pkg;
    localparam int unsigned WORD_W = 16;

    localparam logic [WORD_W-1:0] START_WORD  = 16'h5853;
    localparam logic [WORD_W-1:0] START_REPLY = 16'h5253;
    localparam logic [WORD_W-1:0] PING_WORD   = 16'h590B;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_state_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_SW_SEND,
        SQ_SW_WAIT,
        SQ_PARK,
        SQ_P1_SEND,
        SQ_P1_WAIT,
        SQ_P2_SEND,
        SQ_P2_WAIT,
        SQ_PASS,
        SQ_FAIL
    } seq_state_t;
endpackage

// File: rtl/spi_rate_bank.sv
// Module: spi_rate_bank
// Picks the active divider/gap pair from the slow and fast register sets.
// Assumes the consumer captures the result at word start, so a change here
// never reaches a word already in flight.
module spi_rate_bank #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned GAP_W = 16
) (
    input  logic             use_fast,
    input  logic [DIV_W-1:0] slow_div,
    input  logic [GAP_W-1:0] slow_gap,
    input  logic [DIV_W-1:0] fast_div,
    input  logic [GAP_W-1:0] fast_gap,
    output logic [DIV_W-1:0] div_sel,
    output logic [GAP_W-1:0] gap_sel
);
    localparam int unsigned SETS = 2;

    logic [DIV_W-1:0] div_tab [SETS];
    logic [GAP_W-1:0] gap_tab [SETS];

    assign div_tab[0] = slow_div;
    assign gap_tab[0] = slow_gap;
    assign div_tab[1] = fast_div;
    assign gap_tab[1] = fast_gap;

    // Purpose: index the set table with the select bit.
    always_comb begin
        div_sel = div_tab[use_fast];
        gap_sel = gap_tab[use_fast];
    end
endmodule

// File: rtl/spi_word_engine.sv
// Module: spi_word_engine
// Shifts one full-duplex word per go pulse: chip select low, sclk idles high,
// mosi updated with each falling edge, miso sampled with each rising edge,
// then chip select released for gap+1 cycles before ready returns.
// Assumes go is only raised while ready is high.
module spi_word_engine
    import spi_boot_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned GAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [GAP_W-1:0]  gap_in,
    input  logic              miso,
    output logic              ready,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi
);
    localparam int unsigned EDGES = 2 * WORD_W;
    localparam int unsigned EW    = $clog2(EDGES + 1);

    eng_state_t        st;
    logic [DIV_W-1:0]  div_q;
    logic [GAP_W-1:0]  gap_q;
    logic [DIV_W-1:0]  half_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic [EW-1:0]     edge_cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    assign ready = (st == ENG_IDLE);

    // Purpose: word framing, edge generation, shifting and idle-gap timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ENG_IDLE;
            div_q     <= '0;
            gap_q     <= '0;
            half_cnt  <= '0;
            gap_cnt   <= '0;
            edge_cnt  <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_word   <= '0;
            word_done <= 1'b0;
            sclk      <= 1'b1;
            cs_n      <= 1'b1;
            mosi      <= 1'b0;
        end else begin
            word_done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (go) begin
                        tx_sh    <= tx_word;
                        div_q    <= div_in;
                        gap_q    <= gap_in;
                        half_cnt <= '0;
                        edge_cnt <= '0;
                        cs_n     <= 1'b0;
                        st       <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (half_cnt == div_q) begin
                        half_cnt <= '0;
                        if (edge_cnt == EW'(EDGES)) begin
                            cs_n      <= 1'b1;
                            rx_word   <= rx_sh;
                            word_done <= 1'b1;
                            gap_cnt   <= '0;
                            st        <= ENG_GAP;
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                            sclk     <= ~sclk;
                            if (sclk) begin
                                mosi  <= tx_sh[WORD_W-1];
                                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                            end else begin
                                rx_sh <= {rx_sh[WORD_W-2:0], miso};
                            end
                        end
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                ENG_GAP: begin
                    if (gap_cnt == gap_q) st <= ENG_IDLE;
                    else                  gap_cnt <= gap_cnt + 1'b1;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_sync_fsm.sv
// Module: spi_sync_fsm
// Handshake sequencer: start word with bounded resends, a park point with no
// time limit, then the two ping words and a verdict on the second read-back.
// Assumes the word engine reports each finished word with a one-cycle pulse.
module spi_sync_fsm
    import spi_boot_pkg::*;
#(
    parameter int unsigned RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ping_go,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic [WORD_W-1:0]  ping_expect,
    input  logic               eng_ready,
    input  logic               word_done,
    input  logic [WORD_W-1:0]  rx_word,
    output logic               eng_go,
    output logic [WORD_W-1:0]  tx_word,
    output logic               synced,
    output logic               done,
    output logic               err_start,
    output logic               err_ping
);
    seq_state_t         st;
    logic [RETRY_W-1:0] tries;
    logic               can_start;

    assign can_start = (st == SQ_IDLE) || (st == SQ_PASS) || (st == SQ_FAIL);

    // Purpose: handshake sequencing and sticky outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            tries     <= '0;
            eng_go    <= 1'b0;
            tx_word   <= '0;
            synced    <= 1'b0;
            done      <= 1'b0;
            err_start <= 1'b0;
            err_ping  <= 1'b0;
        end else begin
            eng_go <= 1'b0;
            if (start && can_start) begin
                synced    <= 1'b0;
                done      <= 1'b0;
                err_start <= 1'b0;
                err_ping  <= 1'b0;
                tries     <= '0;
                st        <= SQ_SW_SEND;
            end else begin
                case (st)
                    SQ_SW_SEND: if (eng_ready && !eng_go) begin
                        eng_go  <= 1'b1;
                        tx_word <= START_WORD;
                        st      <= SQ_SW_WAIT;
                    end
                    SQ_SW_WAIT: if (word_done) begin
                        if (rx_word == START_REPLY) begin
                            synced <= 1'b1;
                            st     <= SQ_PARK;
                        end else if (tries == retry_limit) begin
                            err_start <= 1'b1;
                            st        <= SQ_FAIL;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= SQ_SW_SEND;
                        end
                    end
                    SQ_PARK: if (ping_go) st <= SQ_P1_SEND;
                    SQ_P1_SEND: if (eng_ready && !eng_go) begin
                        eng_go  <= 1'b1;
                        tx_word <= PING_WORD;
                        st      <= SQ_P1_WAIT;
                    end
                    SQ_P1_WAIT: if (word_done) st <= SQ_P2_SEND;
                    SQ_P2_SEND: if (eng_ready && !eng_go) begin
                        eng_go  <= 1'b1;
                        tx_word <= START_WORD;
                        st      <= SQ_P2_WAIT;
                    end
                    SQ_P2_WAIT: if (word_done) begin
                        if ((rx_word == ping_expect) && (rx_word != '0)) begin
                            done <= 1'b1;
                            st   <= SQ_PASS;
                        end else begin
                            err_ping <= 1'b1;
                            st       <= SQ_FAIL;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_boot_sync.sv
// Module: spi_boot_sync (top)
// SPI host for the opening handshake of a slave-booting processor: the rate
// bank picks the slow or fast set, the word engine moves 16-bit words, the
// sequencer runs start-word and ping phases.
// Assumes use_fast is steered by the host; it takes effect at the next word.
module spi_boot_sync
    import spi_boot_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned GAP_W   = 16,
    parameter int unsigned RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ping_go,
    input  logic               use_fast,
    input  logic [DIV_W-1:0]   slow_div,
    input  logic [GAP_W-1:0]   slow_gap,
    input  logic [DIV_W-1:0]   fast_div,
    input  logic [GAP_W-1:0]   fast_gap,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic [15:0]        ping_expect,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic               synced,
    output logic               done,
    output logic               err_start,
    output logic               err_ping
);
    logic [DIV_W-1:0]  div_sel;
    logic [GAP_W-1:0]  gap_sel;
    logic              eng_go;
    logic              eng_ready;
    logic              word_done;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rx_word;

    spi_rate_bank #(.DIV_W(DIV_W), .GAP_W(GAP_W)) rate_i (
        .use_fast (use_fast),
        .slow_div (slow_div),
        .slow_gap (slow_gap),
        .fast_div (fast_div),
        .fast_gap (fast_gap),
        .div_sel  (div_sel),
        .gap_sel  (gap_sel)
    );

    spi_word_engine #(.DIV_W(DIV_W), .GAP_W(GAP_W)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (eng_go),
        .tx_word   (tx_word),
        .div_in    (div_sel),
        .gap_in    (gap_sel),
        .miso      (miso),
        .ready     (eng_ready),
        .word_done (word_done),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi)
    );

    spi_sync_fsm #(.RETRY_W(RETRY_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ping_go     (ping_go),
        .retry_limit (retry_limit),
        .ping_expect (ping_expect),
        .eng_ready   (eng_ready),
        .word_done   (word_done),
        .rx_word     (rx_word),
        .eng_go      (eng_go),
        .tx_word     (tx_word),
        .synced      (synced),
        .done        (done),
        .err_start   (err_start),
        .err_ping    (err_ping)
    );
endmodule

// File: rtl/spi_boot_sync_chk.sv
// Module: spi_boot_sync_chk
// Port-level checker for spi_boot_sync, attached with bind below.
// Assumes gap settings are held steady while words are in flight.
module spi_boot_sync_chk #(
    parameter int unsigned GAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sclk,
    input logic             cs_n,
    input logic             mosi,
    input logic             done,
    input logic             err_start,
    input logic             err_ping,
    input logic [GAP_W-1:0] slow_gap,
    input logic [GAP_W-1:0] fast_gap
);
    logic [5:0]       rise_cnt;
    logic             sclk_q;
    logic [GAP_W:0]   hi_cnt;
    logic [GAP_W-1:0] gap_min;

    assign gap_min = (slow_gap < fast_gap) ? slow_gap : fast_gap;

    // Purpose: count rising sclk edges inside the current chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            sclk_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            if (cs_n)                  rise_cnt <= '0;
            else if (sclk && !sclk_q)  rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // Purpose: measure the chip-select high run, saturating, starting full.
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_cnt <= '1;
        else if (!cs_n)         hi_cnt <= '0;
        else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
    end

    assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    assert_mosi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk));

    assert_sixteen_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 6'd16));

    assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= ({1'b0, gap_min} + 1'b1)));

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_start, err_ping}));

    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && !$past(start)) |-> done);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_start || err_ping) && !$past(start)) |-> (err_start || err_ping));
endmodule

bind spi_boot_sync spi_boot_sync_chk #(.GAP_W(GAP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .done      (done),
    .err_start (err_start),
    .err_ping  (err_ping),
    .slow_gap  (slow_gap),
    .fast_gap  (fast_gap)
);

// File: tb/spi_boot_sync_tb_top.sv
// Bench: directed scenarios against a behavioural SPI slave and a timing monitor.
module spi_boot_sync_tb_top;
    localparam int DIV_W = 8;
    localparam int GAP_W = 16;
    localparam int RW    = 8;
    localparam int SLOW_DIV = 3;
    localparam int SLOW_GAP = 10;
    localparam int FAST_DIV = 1;
    localparam int FAST_GAP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             ping_go = 1'b0;
    logic             use_fast = 1'b0;
    logic [RW-1:0]    retry_limit = 8'd2;
    logic [15:0]      ping_expect = 16'h590B;
    logic             miso = 1'b0;
    logic             sclk, cs_n, mosi, synced, done, err_start, err_ping;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // slave model state
    logic [15:0] reply_q [32];
    logic [15:0] sent_q  [32];
    int          bits_q  [32];
    int          ridx = 0;
    int          nsent = 0;
    logic [15:0] cur_reply = '0;
    logic [15:0] rx_sh = '0;
    int          bitp = 15;
    int          nbits = 0;

    // monitor state
    int hmin [32];
    int hmax [32];
    int gap_before [32];
    int run = 0;
    int hi_run = 0;
    logic prev_sclk = 1'b1;
    logic prev_cs = 1'b1;

    spi_boot_sync #(.DIV_W(DIV_W), .GAP_W(GAP_W), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ping_go(ping_go),
        .use_fast(use_fast),
        .slow_div(8'(SLOW_DIV)), .slow_gap(16'(SLOW_GAP)),
        .fast_div(8'(FAST_DIV)), .fast_gap(16'(FAST_GAP)),
        .retry_limit(retry_limit), .ping_expect(ping_expect), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .synced(synced), .done(done),
        .err_start(err_start), .err_ping(err_ping)
    );

    always #2 clk = ~clk;

    // slave: load reply at select, shift out on falling, capture on rising
    always @(negedge cs_n) begin
        cur_reply = reply_q[ridx];
        ridx = ridx + 1;
        bitp = 15;
        nbits = 0;
    end
    always @(negedge sclk) if (!cs_n) begin
        miso = cur_reply[bitp];
        bitp = bitp - 1;
    end
    always @(posedge sclk) if (!cs_n) begin
        rx_sh = {rx_sh[14:0], mosi};
        nbits = nbits + 1;
    end
    always @(posedge cs_n) begin
        sent_q[nsent] = rx_sh;
        bits_q[nsent] = nbits;
        nsent = nsent + 1;
    end

    // monitor: sclk level lengths and cs high runs in clock cycles
    always @(negedge clk) begin
        if (cs_n) begin
            hi_run = hi_run + 1;
            run = 0;
        end else begin
            if (prev_cs) begin
                gap_before[nsent] = hi_run;
                hi_run = 0;
                run = 1;
            end else if (sclk != prev_sclk) begin
                if (run < hmin[nsent]) hmin[nsent] = run;
                if (run > hmax[nsent]) hmax[nsent] = run;
                run = 1;
            end else begin
                run = run + 1;
            end
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_slave(input logic [15:0] r0, input logic [15:0] r1,
                               input logic [15:0] r2, input logic [15:0] r3,
                               input logic [15:0] r4);
        for (int i = 0; i < 32; i++) begin
            reply_q[i] = 16'h0000;
            sent_q[i] = 16'h0000;
            bits_q[i] = 0;
            hmin[i] = 1000000;
            hmax[i] = 0;
            gap_before[i] = 1000000;
        end
        reply_q[0] = r0; reply_q[1] = r1; reply_q[2] = r2;
        reply_q[3] = r3; reply_q[4] = r4;
        ridx = 0;
        nsent = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_synced_or_err(input string tag);
        int n = 0;
        while (!synced && !err_start && n < 20000) begin @(negedge clk); n++; end
        check(n < 20000, tag, n, 0);
    endtask

    task automatic wait_outcome(input string tag);
        int n = 0;
        while (!done && !err_start && !err_ping && n < 20000) begin @(negedge clk); n++; end
        check(n < 20000, tag, n, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(4);
        check(cs_n === 1'b1 && sclk === 1'b1 && mosi === 1'b0, "R1 lines", {cs_n, sclk, mosi}, 3'b110);
        check({synced, done, err_start, err_ping} === 4'b0, "R1 flags",
              {synced, done, err_start, err_ping}, 0);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_plain_slow();
        use_fast = 1'b0; ping_expect = 16'h590B; ping_go = 1'b0;
        clear_slave(16'h5253, 16'h0000, 16'h590B, 0, 0);
        pulse_start();
        wait_synced_or_err("R3 wait synced");
        idle(2);
        check(synced === 1'b1 && nsent == 1, "R3 synced after one word", nsent, 1);
        check(sent_q[0] == 16'h5853, "R3 start word", sent_q[0], 16'h5853);
        check(bits_q[0] == 16, "R2 sixteen edges", bits_q[0], 16);
        check(hmin[0] == SLOW_DIV + 1 && hmax[0] == SLOW_DIV + 1, "R10 slow half period",
              hmax[0], SLOW_DIV + 1);
        idle(400);
        check(nsent == 1 && !done && !err_ping, "R6 parked without ping_go", nsent, 1);
        ping_go = 1'b1;
        wait_outcome("R7 wait outcome");
        ping_go = 1'b0;
        idle(2);
        check(done === 1'b1 && !err_ping && !err_start, "R7 done on match", done, 1);
        check(nsent == 3 && sent_q[1] == 16'h590B && sent_q[2] == 16'h5853,
              "R6 ping words", sent_q[1], 16'h590B);
        check(gap_before[2] >= SLOW_GAP + 1, "R9 slow gap", gap_before[2], SLOW_GAP + 1);
        idle(100);
        check(done === 1'b1, "R12 done held", done, 1);
    endtask

    task automatic t_retry_ok();
        retry_limit = 8'd2;
        clear_slave(16'h1111, 16'h0000, 16'h5253, 16'h0000, 16'h590B);
        pulse_start();
        check(done === 1'b0, "R12 start clears done", done, 0);
        wait_synced_or_err("R4 wait synced");
        idle(2);
        check(synced === 1'b1 && !err_start && nsent == 3, "R4 match on last allowed try", nsent, 3);
        check(sent_q[1] == 16'h5853 && sent_q[2] == 16'h5853, "R4 resent start word",
              sent_q[1], 16'h5853);
        check(gap_before[1] >= SLOW_GAP + 1, "R9 gap between resends", gap_before[1], SLOW_GAP + 1);
        ping_go = 1'b1;
        wait_outcome("R4 finish");
        ping_go = 1'b0;
        check(done === 1'b1, "R7 done after retries", done, 1);
    endtask

    task automatic t_retry_exhaust();
        retry_limit = 8'd2;
        clear_slave(16'h1234, 16'h1234, 16'h1234, 16'h5253, 16'h5253);
        pulse_start();
        wait_outcome("R5 wait error");
        idle(300);
        check(err_start === 1'b1 && !synced && !done, "R5 err_start", err_start, 1);
        check(nsent == 3, "R5 word count at limit", nsent, 3);
    endtask

    task automatic t_ping_zero();
        ping_expect = 16'h0000;
        clear_slave(16'h5253, 16'h0000, 16'h0000, 0, 0);
        pulse_start();
        check(err_start === 1'b0, "R12 start clears err_start", err_start, 0);
        wait_synced_or_err("R8 zero synced");
        ping_go = 1'b1;
        wait_outcome("R8 zero outcome");
        ping_go = 1'b0;
        idle(2);
        check(err_ping === 1'b1 && !done, "R8 zero reply rejected", err_ping, 1);
        ping_expect = 16'h590B;
    endtask

    task automatic t_ping_wrong();
        clear_slave(16'h5253, 16'h0000, 16'h1234, 0, 0);
        pulse_start();
        wait_synced_or_err("R8 wrong synced");
        ping_go = 1'b1;
        wait_outcome("R8 wrong outcome");
        ping_go = 1'b0;
        idle(2);
        check(err_ping === 1'b1 && !done, "R8 wrong reply rejected", err_ping, 1);
    endtask

    task automatic t_fast();
        use_fast = 1'b1;
        clear_slave(16'h5253, 16'h0000, 16'h590B, 0, 0);
        pulse_start();
        idle(2);
        check(err_ping === 1'b0, "R12 start clears err_ping", err_ping, 0);
        wait_synced_or_err("R10 fast synced");
        ping_go = 1'b1;
        wait_outcome("R10 fast outcome");
        ping_go = 1'b0;
        idle(2);
        check(done === 1'b1, "R7 done fast", done, 1);
        check(hmin[1] == FAST_DIV + 1 && hmax[1] == FAST_DIV + 1, "R10 fast half period",
              hmax[1], FAST_DIV + 1);
        check(gap_before[2] >= FAST_GAP + 1, "R9 fast gap", gap_before[2], FAST_GAP + 1);
        use_fast = 1'b0;
    endtask

    task automatic t_switch_midword();
        int n = 0;
        use_fast = 1'b0;
        clear_slave(16'h7777, 16'h5253, 16'h0000, 16'h590B, 0);
        pulse_start();
        while (cs_n && n < 1000) begin @(negedge clk); n++; end
        idle(6);
        use_fast = 1'b1;
        wait_synced_or_err("R11 synced");
        idle(2);
        check(hmin[0] == SLOW_DIV + 1 && hmax[0] == SLOW_DIV + 1, "R11 word kept slow set",
              hmax[0], SLOW_DIV + 1);
        check(hmin[1] == FAST_DIV + 1 && hmax[1] == FAST_DIV + 1, "R11 next word fast",
              hmax[1], FAST_DIV + 1);
        ping_go = 1'b1;
        wait_outcome("R11 finish");
        ping_go = 1'b0;
        use_fast = 1'b0;
    endtask

    initial begin
        t_reset();
        t_plain_slow();
        t_retry_ok();
        t_retry_exhaust();
        t_ping_zero();
        t_ping_wrong();
        t_fast();
        t_switch_midword();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule